// File: doc/BRIEF.md
# SD Card Command Channel Engine

This block drives the command line of an SD/MMC card on behalf of software. Software first writes a 32-bit argument word, then a command word that carries the command index, response options and a start flag. The engine sends a 48-bit frame on the command line, adding the start bit, the host direction bit, a CRC7 checksum and the end bit. It then releases the line and, if the command expects an answer, waits for the card to start one.

A reply comes in one of two lengths. A short reply is 48 bits; the engine checks its CRC7 and stores its 32-bit body and index. A long reply is 136 bits; the engine stores its 128-bit payload across four response words without checking a CRC. The outcome is recorded in sticky status flags: command sent, reply received, reply timed out, or reply CRC wrong. Software clears each flag by writing a one to its position in a separate clear register. A clock register gates the card clock. The engine moves one bit per system clock while the card clock is enabled and holds still while it is disabled.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the status word reads 0, `cmd_oe` is low, `card_clk_en` is low and every response word (offsets 0x14, 0x18, 0x1C, 0x20) reads 0.
- R2: Bit 8 of the clock register (offset 0x04) drives `card_clk_en` and reads back. While it is 0, a launched command holds its current line bit and makes no progress. Once it is set, the command carries on from that bit.
- R3: A write to the command register (offset 0x0C) with bit 10 set launches a command. The 48-bit frame goes out MSB first, one bit per cycle while the card clock is enabled, with `cmd_oe` high for the whole frame. The frame is: 0, 1, command bits [5:0], the argument (offset 0x08, MSB first), a CRC7 and a 1. The CRC7 uses x^7+x^3+1, starts at zero, and covers the 40 preceding bits.
- R4: When bit 6 of the command word is clear, status bit 7 (sent) is set once the end bit has gone out, and the engine becomes idle.
- R5: When bit 6 is set, a reply start bit (0 on `cmd_in`) must arrive within 64 card clock cycles after the end bit. A start bit in the 64th cycle is still accepted. Otherwise status bit 2 (timeout) is set, and any later start bit is ignored.
- R6: A short reply (bit 6 set, bit 7 clear) is 48 bits. Its bits [39:8] go to response word 0 and bits [45:40] to the index register (offset 0x10); response words 1 to 3 are unchanged. Its CRC7 over bits [47:8] is checked: a match sets status bit 6, a mismatch sets status bit 0 only.
- R7: A long reply (bits 6 and 7 set) is 136 bits. Its last 128 bits go to response words 0 to 3, with word 0 holding the most significant 32 bits. The 6-bit field after the transmission bit goes to the index register. No CRC is checked, and status bit 6 is set.
- R8: Status bit 11 (active) is high from the launch until the command completes or is aborted.
- R9: Status bits 0, 2, 6 and 7 are sticky. A write to the clear register (offset 0x38) clears each of these bits that has a one in the written word and leaves the others unchanged. An event in the same cycle as a clear takes priority over the clear.
- R10: A write to the command register with bit 10 clear aborts any command in progress. It releases the line and sets no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| card_clk_en | output | 1 | Card clock enable |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The assertions assume that, while the card clock is disabled, nothing drives the register bus. They also assume that bus writes never share a cycle with the engine's own completion of a command. The bench writes registers only at the falling edge, and only when the engine is idle or during a deliberate pause (the gating and abort tests). The card model drives `cmd_in` only at falling edges and only after the engine has released the line. The model holds the line high whenever it is not replying, including while the engine is sending.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   // register byte offsets
   localparam int OFS_CLK   = 'h04;
   localparam int OFS_ARG   = 'h08;
   localparam int OFS_CMD   = 'h0C;
   localparam int OFS_RIDX  = 'h10;
   localparam int OFS_RESP0 = 'h14;
   localparam int OFS_STAT  = 'h34;
   localparam int OFS_CLR   = 'h38;

   // field positions
   localparam int CK_EN   = 8;
   localparam int CW_WAIT = 6;
   localparam int CW_LONG = 7;
   localparam int CW_GO   = 10;
   localparam int ST_CRC  = 0;
   localparam int ST_TO   = 2;
   localparam int ST_REND = 6;
   localparam int ST_SENT = 7;
   localparam int ST_ACT  = 11;

   localparam int          CRC_W    = 7;
   localparam logic [6:0]  CRC_POLY = 7'h09;

   typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_WAIT, PH_RECV} phase_e;

   typedef struct packed {
      logic crc_bad;
      logic timeout;
      logic resp_end;
      logic sent;
   } evt_t;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
   parameter int         W    = 7,
   parameter logic [W-1:0] POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         feed,
   input  logic         din,
   output logic [W-1:0] crc
);
   // Feeding din equal to the MSB makes the register a plain left shift,
   // which the serializer uses to put the checksum on the line.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= '0;
      else if (clear) crc <= '0;
      else if (feed)  crc <= {crc[W-2:0], 1'b0} ^ ((din ^ crc[W-1]) ? POLY : '0);
   end
endmodule

// File: rtl/sdcmd_link.sv
module sdcmd_link
   import sdcmd_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter int ARG_W     = 32,
   parameter int TIMEOUT   = 64,
   parameter int SHORT_LEN = 48,
   parameter int LONG_LEN  = 136
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 launch,
   input  logic                 abort,
   input  logic [IDX_W-1:0]     idx,
   input  logic [ARG_W-1:0]     arg,
   input  logic                 want_resp,
   input  logic                 want_long,
   input  logic                 cmd_in,
   output logic                 cmd_out,
   output logic                 cmd_oe,
   output logic                 active,
   output evt_t                 evt,
   output logic                 cap_short,
   output logic                 cap_long,
   output logic [LONG_LEN-3:0]  rx_frame
);
   localparam int TX_BITS = 2 + IDX_W + ARG_W + CRC_W + 1;
   localparam int CNT_W   = $clog2(LONG_LEN);
   localparam int TO_W    = $clog2(TIMEOUT);
   localparam int CI_W    = $clog2(CRC_W);

   if (TX_BITS != SHORT_LEN) begin : g_len_chk
      $error("command frame length must equal SHORT_LEN");
   end
   if (TIMEOUT < 2) begin : g_to_chk
      $error("TIMEOUT must be at least 2");
   end

   phase_e              phase_q;
   logic [CNT_W-1:0]    bcnt_q;
   logic [TX_BITS-1:0]  tx_q;
   logic                want_q, long_q;
   logic [TO_W-1:0]     wcnt_q;
   logic [LONG_LEN-2:0] rx_q, rx_next;
   logic [CRC_W-1:0]    crc;
   logic                tx_bit, crc_clear, crc_feed, crc_din, last, crc_ok;

   assign rx_next  = {rx_q[LONG_LEN-3:0], cmd_in};
   assign rx_frame = rx_next[LONG_LEN-3:0];
   assign last     = (bcnt_q == '0);

   always_comb begin
      if (bcnt_q > CNT_W'(CRC_W)) tx_bit = tx_q[TX_BITS-1];
      else if (last)              tx_bit = 1'b1;
      else                        tx_bit = crc[CRC_W-1];
   end

   assign crc_clear = launch || (tick && phase_q == PH_WAIT && !cmd_in);
   assign crc_feed  = tick && ((phase_q == PH_SEND && !last) ||
                     (phase_q == PH_RECV && !long_q && bcnt_q > CNT_W'(CRC_W)));
   assign crc_din   = (phase_q == PH_SEND) ? tx_bit : cmd_in;
   assign crc_ok    = (crc == rx_next[CRC_W:1]);

   sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(crc_clear), .feed(crc_feed),
      .din(crc_din), .crc(crc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bcnt_q  <= '0;
         tx_q    <= '0;
         want_q  <= 1'b0;
         long_q  <= 1'b0;
         wcnt_q  <= '0;
         rx_q    <= '0;
      end else if (abort) begin
         phase_q <= PH_IDLE;
      end else if (launch) begin
         phase_q <= PH_SEND;
         bcnt_q  <= CNT_W'(TX_BITS - 1);
         tx_q    <= {1'b0, 1'b1, idx, arg, {CRC_W{1'b0}}, 1'b1};
         want_q  <= want_resp;
         long_q  <= want_resp && want_long;
      end else if (tick) begin
         unique case (phase_q)
            PH_SEND: begin
               tx_q <= tx_q << 1;
               if (last) begin
                  phase_q <= want_q ? PH_WAIT : PH_IDLE;
                  wcnt_q  <= '0;
               end else begin
                  bcnt_q <= bcnt_q - 1'b1;
               end
            end
            PH_WAIT: begin
               if (!cmd_in) begin
                  phase_q <= PH_RECV;
                  bcnt_q  <= long_q ? CNT_W'(LONG_LEN - 2) : CNT_W'(SHORT_LEN - 2);
               end else if (wcnt_q == TO_W'(TIMEOUT - 1)) begin
                  phase_q <= PH_IDLE;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            PH_RECV: begin
               rx_q <= rx_next;
               if (last) phase_q <= PH_IDLE;
               else      bcnt_q  <= bcnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      evt       = '0;
      cap_short = 1'b0;
      cap_long  = 1'b0;
      if (tick && !launch && !abort) begin
         if (phase_q == PH_SEND && last && !want_q) evt.sent = 1'b1;
         if (phase_q == PH_WAIT && cmd_in && wcnt_q == TO_W'(TIMEOUT - 1)) evt.timeout = 1'b1;
         if (phase_q == PH_RECV && last) begin
            if (long_q) begin
               cap_long     = 1'b1;
               evt.resp_end = 1'b1;
            end else begin
               cap_short    = 1'b1;
               evt.resp_end = crc_ok;
               evt.crc_bad  = !crc_ok;
            end
         end
      end
   end

   assign active  = (phase_q != PH_IDLE);
   assign cmd_oe  = (phase_q == PH_SEND);
   assign cmd_out = cmd_oe ? tx_bit : 1'b1;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 6,
   parameter int RESP_TIMEOUT = 64,
   parameter int RESP_WORDS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              card_clk_en,
   output logic              cmd_out,
   output logic              cmd_oe,
   input  logic              cmd_in
);
   localparam int SHORT_LEN = 2 + IDX_W + DATA_W + CRC_W + 1;
   localparam int PAY_W     = RESP_WORDS * DATA_W;
   localparam int LONG_LEN  = PAY_W + 8;

   if (DATA_W != 32) begin : g_dw_chk
      $error("DATA_W must be 32");
   end
   if (IDX_W != 6) begin : g_idx_chk
      $error("IDX_W must be 6");
   end

   logic              clk_en_q;
   logic [DATA_W-1:0] arg_q;
   logic [CW_GO-1:0]  cmdw_q;
   logic [IDX_W-1:0]  ridx_q;
   logic [DATA_W-1:0] resp_q [RESP_WORDS];
   evt_t              sticky_q, evt, clr_mask;
   logic              wr_cmd, launch, abort, link_active, cap_short, cap_long;
   logic [LONG_LEN-3:0] rx_frame;

   assign wr_cmd = bus_we && bus_addr == ADDR_W'(OFS_CMD);
   assign launch = wr_cmd && bus_wdata[CW_GO];
   assign abort  = wr_cmd && !bus_wdata[CW_GO];

   sdcmd_link #(.IDX_W(IDX_W), .ARG_W(DATA_W), .TIMEOUT(RESP_TIMEOUT),
                .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_link (
      .clk(clk), .rst_n(rst_n), .tick(clk_en_q), .launch(launch), .abort(abort),
      .idx(bus_wdata[IDX_W-1:0]), .arg(arg_q),
      .want_resp(bus_wdata[CW_WAIT]), .want_long(bus_wdata[CW_LONG]),
      .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .active(link_active),
      .evt(evt), .cap_short(cap_short), .cap_long(cap_long), .rx_frame(rx_frame));

   always_comb begin
      clr_mask = '0;
      if (bus_we && bus_addr == ADDR_W'(OFS_CLR)) begin
         clr_mask.crc_bad  = bus_wdata[ST_CRC];
         clr_mask.timeout  = bus_wdata[ST_TO];
         clr_mask.resp_end = bus_wdata[ST_REND];
         clr_mask.sent     = bus_wdata[ST_SENT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_en_q <= 1'b0;
         arg_q    <= '0;
         cmdw_q   <= '0;
         ridx_q   <= '0;
         sticky_q <= '0;
      end else begin
         sticky_q <= (sticky_q & ~clr_mask) | evt;
         if (bus_we && bus_addr == ADDR_W'(OFS_CLK)) clk_en_q <= bus_wdata[CK_EN];
         if (bus_we && bus_addr == ADDR_W'(OFS_ARG)) arg_q    <= bus_wdata;
         if (wr_cmd)    cmdw_q <= bus_wdata[CW_GO-1:0];
         if (cap_long)  ridx_q <= rx_frame[LONG_LEN-3 -: IDX_W];
         if (cap_short) ridx_q <= rx_frame[SHORT_LEN-3 -: IDX_W];
      end
   end

   for (genvar gi = 0; gi < RESP_WORDS; gi++) begin : g_resp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   resp_q[gi] <= '0;
         else if (cap_long)            resp_q[gi] <= rx_frame[PAY_W-1-DATA_W*gi -: DATA_W];
         else if (cap_short && gi == 0) resp_q[gi] <= rx_frame[DATA_W+CRC_W -: DATA_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CLK))  bus_rdata[CK_EN] = clk_en_q;
      if (bus_addr == ADDR_W'(OFS_ARG))  bus_rdata = arg_q;
      if (bus_addr == ADDR_W'(OFS_CMD))  bus_rdata = {{(DATA_W-CW_GO-1){1'b0}}, link_active, cmdw_q};
      if (bus_addr == ADDR_W'(OFS_RIDX)) bus_rdata = {{(DATA_W-IDX_W){1'b0}}, ridx_q};
      if (bus_addr == ADDR_W'(OFS_STAT)) begin
         bus_rdata[ST_CRC]  = sticky_q.crc_bad;
         bus_rdata[ST_TO]   = sticky_q.timeout;
         bus_rdata[ST_REND] = sticky_q.resp_end;
         bus_rdata[ST_SENT] = sticky_q.sent;
         bus_rdata[ST_ACT]  = link_active;
      end
      for (int i = 0; i < RESP_WORDS; i++)
         if (bus_addr == ADDR_W'(OFS_RESP0 + 4 * i)) bus_rdata = resp_q[i];
   end

   assign card_clk_en = clk_en_q;
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk
   import sdcmd_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              go_bit,
   input logic              card_clk_en,
   input logic              cmd_out,
   input logic              cmd_oe,
   input logic              active,
   input logic [3:0]        sticky
);
   logic wr_cmd, wr_clr;
   assign wr_cmd = bus_we && bus_addr == ADDR_W'(OFS_CMD);
   assign wr_clr = bus_we && bus_addr == ADDR_W'(OFS_CLR);

   a_r8_oe_within_active: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> active);

   a_r2_frozen_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_clk_en && !bus_we) |=> ($stable(cmd_out) && $stable(cmd_oe)));

   a_r3_launch_drives_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && go_bit) |=> (cmd_oe && !cmd_out && active));

   a_r9_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_clr |=> ((sticky & $past(sticky)) == $past(sticky)));

   a_r10_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !go_bit) |=> (!active && !cmd_oe));

   a_r4_sent_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky[0]) |-> (!active || $past(bus_we)));

   a_r5_timeout_line_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky[2]) |-> !cmd_oe);
endmodule

bind sdcmd_engine sdcmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .go_bit(bus_wdata[sdcmd_pkg::CW_GO]), .card_clk_en(card_clk_en),
   .cmd_out(cmd_out), .cmd_oe(cmd_oe), .active(link_active), .sticky(sticky_q));

// File: tb/sdcmd_engine_bench.sv
module sdcmd_engine_bench;
   localparam int TMO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        card_clk_en, cmd_out, cmd_oe;
   logic        cmd_in = 1'b1;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   sdcmd_engine u_sdcmd_engine (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_clk_en(card_clk_en),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in));

   always #5 clk = ~clk;

   // {exp_status12, gap8, mode2 (0 reply,1 bad crc,2 silent), long1, wait1, arg32, idx6}
   localparam logic [61:0] VEC [8] = '{
      {12'h080, 8'd0,  2'd0, 1'b0, 1'b0, 32'h0000_0000, 6'd0},
      {12'h040, 8'd2,  2'd0, 1'b0, 1'b1, 32'h0000_0200, 6'd17},
      {12'h040, 8'd1,  2'd0, 1'b1, 1'b1, 32'h0BAD_F00D, 6'd2},
      {12'h040, 8'd63, 2'd0, 1'b0, 1'b1, 32'h0000_01AA, 6'd8},
      {12'h001, 8'd5,  2'd1, 1'b0, 1'b1, 32'hDEAD_BEEF, 6'd55},
      {12'h004, 8'd0,  2'd2, 1'b0, 1'b1, 32'h1234_5678, 6'd13},
      {12'h004, 8'd64, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 6'd9},
      {12'h080, 8'd0,  2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 6'd63}
   };

   logic [47:0]  frame;
   logic [31:0]  rd;
   logic [31:0]  mdl [4];
   logic [5:0]   mdl_idx;

   function automatic logic [6:0] crc7(input logic [39:0] d);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb = d[i] ^ c[6];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [127:0] long_pay(input logic [31:0] a, input logic [5:0] ix);
      return {a, ~a, a ^ 32'h5555_AAAA, 32'h0F1E_2D00 | {26'd0, ix}};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic br(input logic [7:0] a);
      bus_addr = a;
      #1;
      rd = bus_rdata;
   endtask

   task automatic capture();
      frame = '0;
      for (int i = 0; i < 48; i++) begin
         frame = {frame[46:0], cmd_out & cmd_oe};
         @(negedge clk);
      end
   endtask

   function automatic logic [47:0] exp_frame(input logic [5:0] ix, input logic [31:0] a);
      logic [39:0] h = {2'b01, ix, a};
      return {h, crc7(h), 1'b1};
   endfunction

   task automatic do_cmd(input logic [5:0] ix, input logic [31:0] a, input logic wt,
                         input logic lng, input logic [1:0] mode, input int gap);
      logic [135:0] rsp;
      logic [39:0]  hd;
      logic [6:0]   c;
      int           n;
      bw(8'h08, a);
      bw(8'h0C, {21'd0, 1'b1, 2'b00, lng, wt, ix});
      capture();
      if (wt) begin
         if (mode == 2'd2) begin
            repeat (TMO + 8) @(negedge clk);
         end else begin
            repeat (gap) begin cmd_in = 1'b1; @(negedge clk); end
            if (lng) begin
               rsp = {2'b00, 6'h3F, long_pay(a, ix)};
               n = 136;
            end else begin
               hd  = {2'b00, ix, a ^ 32'hA5A5_0F0F};
               c   = crc7(hd) ^ ((mode == 2'd1) ? 7'h01 : 7'h00);
               rsp = {88'd0, hd, c, 1'b1};
               n = 48;
            end
            for (int j = n - 1; j >= 0; j--) begin
               cmd_in = rsp[j];
               @(negedge clk);
            end
            cmd_in = 1'b1;
            repeat (2) @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      mdl_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      br(8'h34); chk("R1 status", rd, 0);
      chk("R1 cmd_oe", cmd_oe, 0);
      chk("R1 card_clk_en", card_clk_en, 0);
      for (int i = 0; i < 4; i++) begin
         br(8'(8'h14 + 4 * i)); chk("R1 resp word", rd, 0);
      end

      // R2 gated card clock holds the frame at its start bit
      bw(8'h08, 32'h0000_0055);
      bw(8'h0C, 32'h0000_0405);
      repeat (10) @(negedge clk);
      br(8'h34); chk("R2 hold status", rd, 32'h800);
      chk("R2 hold oe", cmd_oe, 1);
      chk("R2 hold bit", cmd_out, 0);
      bw(8'h04, 32'h0000_0100);
      chk("R2 clk_en", card_clk_en, 1);
      br(8'h04); chk("R2 clk readback", rd, 32'h100);
      capture();
      chk("R2 frame after ungate", frame, exp_frame(6'd5, 32'h55));
      br(8'h34); chk("R4 status", rd, 32'h080);
      bw(8'h38, 32'h0000_00C5);

      // table walk: R3 frames, R4..R7 outcomes, R9 clear
      for (int v = 0; v < 8; v++) begin
         logic [61:0] e = VEC[v];
         logic [5:0]  ix = e[5:0];
         logic [31:0] a = e[37:6];
         logic        wt = e[38];
         logic        lng = e[39];
         logic [11:0] xs = e[61:50];
         string       tag;
         do_cmd(ix, a, wt, lng, e[41:40], int'(e[49:42]));
         chk("R3 frame", frame, exp_frame(ix, a));
         if (xs[6] || xs[0]) begin
            if (lng) begin
               logic [127:0] p = long_pay(a, ix);
               mdl[0] = p[127:96]; mdl[1] = p[95:64]; mdl[2] = p[63:32]; mdl[3] = p[31:0];
               mdl_idx = 6'h3F;
            end else begin
               mdl[0] = a ^ 32'hA5A5_0F0F;
               mdl_idx = ix;
            end
         end
         if (xs[7])      tag = "R4 status";
         else if (xs[2]) tag = "R5 status";
         else if (lng)   tag = "R7 status";
         else            tag = "R6 status";
         br(8'h34); chk(tag, rd, {20'd0, xs});
         br(8'h10); chk(lng ? "R7 index" : "R6 index", rd, {26'd0, mdl_idx});
         for (int i = 0; i < 4; i++) begin
            br(8'(8'h14 + 4 * i));
            chk(lng ? "R7 resp word" : "R6 resp word", rd, mdl[i]);
         end
         bw(8'h38, 32'h0000_00C5);
         br(8'h34); chk("R9 cleared", rd, 0);
      end

      // R10 abort mid-frame
      bw(8'h0C, 32'h0000_0443);
      repeat (10) @(negedge clk);
      bw(8'h0C, 32'h0000_0000);
      br(8'h34); chk("R10 status after abort", rd, 0);
      chk("R10 oe after abort", cmd_oe, 0);
      repeat (TMO + 60) @(negedge clk);
      br(8'h34); chk("R10 no late flag", rd, 0);

      // R9 selective write-one-to-clear
      do_cmd(6'd1, 32'h0, 1'b0, 1'b0, 2'd0, 0);
      do_cmd(6'd2, 32'h0, 1'b1, 1'b0, 2'd2, 0);
      br(8'h34); chk("R9 both set", rd, 32'h084);
      bw(8'h38, 32'h0000_0040);
      br(8'h34); chk("R9 clear unset bit", rd, 32'h084);
      bw(8'h38, 32'h0000_0004);
      br(8'h34); chk("R9 clear timeout only", rd, 32'h080);
      bw(8'h38, 32'h0000_0080);
      br(8'h34); chk("R9 clear sent", rd, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule